// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Unit

This unit gathers the condition signals of a flash controller (device ready, controller ready, decode failure, decode error, ECC ready, write-protect fault) and turns them into three software-visible registers plus one interrupt line. A live status word mirrors the current conditions, including a two-bit count of corrected symbol errors. A sticky word latches every rising edge of a condition and is emptied when software reads it. A mask word selects which sticky flags drive the interrupt output, which is a level, active high, for as long as any enabled flag is held.

Register access is a plain single-cycle request: a read or write strobe with a two-bit selector. Reads answer one cycle later with a valid pulse. The port takes one request per cycle and has no back-pressure, so a requester may issue reads back to back. Selector codes: 0 live status, 1 sticky flags, 2 mask, 3 reserved (reads zero).

Top module: `irq_stat_unit`

## Requirements
- R1: After reset the mask and sticky flags are all zero, the interrupt output is low and no read answer is pending.
- R2: Sticky flag bit positions are 5 device ready, 4 controller ready, 3 decode failure, 2 decode error, 1 ECC ready, 0 write-protect fault; a flag sets on the rising edge of its condition only, so a condition that stays high does not set it again after it has been cleared.
- R3: A read with selector 1 returns the sticky flags as they stood in the request cycle and clears them.
- R4: A condition edge in the same cycle as a clearing read is not lost: its flag is set after the read.
- R5: The live status word has bit 0 device ready, 1 controller ready, 2 ECC ready, 3 errors detected, 5:4 corrected-error count (errors minus one), 6 decode failure, 7 zero; the count field reads zero while bit 3 is low.
- R6: Reading the live status word leaves the sticky flags untouched.
- R7: The mask (selector 2) is read/write in bits 5:0 with the same bit layout as the sticky flags; bits 7:6 read zero.
- R8: The interrupt output is high exactly while some sticky flag and its mask bit are both set, visible the cycle after the edge that sets the flag.
- R9: Every read raises the valid output for exactly the following cycle, carrying the data of the request cycle; selector 3 reads zero.
- R10: Writes with selector 0, 1 or 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_rdy_i | input | 1 | Flash device ready condition |
| ctl_rdy_i | input | 1 | Controller ready condition |
| dec_fail_i | input | 1 | Uncorrectable decode condition |
| dec_err_i | input | 1 | Errors detected (corrected) condition |
| ecc_rdy_i | input | 1 | ECC result ready condition |
| wp_fault_i | input | 1 | Write-protect fault condition |
| err_cnt_i | input | 2 | Corrected error count minus one |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| sel_i | input | 2 | Register selector |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data |
| rd_valid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
A condition driven before a clock edge shows up in the sticky flags and on the interrupt line right after that edge, a one-cycle latency; a read or write request gives its answer, and its clearing or mask update, after the next edge. The bench drives inputs and samples outputs on the falling edge, so each result is read exactly half a cycle after the edge that produces it. The sweeps cover all 64 mask values against each of the six sources and all 128 combinations of the live status inputs.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int SRC_N = 6;
  localparam int CNT_W = 2;

  typedef enum logic [1:0] {
    SEL_LIVE   = 2'd0,
    SEL_STICKY = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_RSVD   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] level_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_i[g];
    end
    assign rise_o[g] = level_i[g] & ~prev_q;
  end
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (clr_i ? '0 : flags_q) | set_i;
  end
  assign flags_o = flags_q;

  // R4
  no_lost_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));

  // R3
  clr_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i == '0) |=> (flags_q == '0));

  // R6
  hold_without_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && set_i == '0) |=> $stable(flags_q));
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_stat_pkg::*;
#(
  parameter int DW = 8,
  parameter int N  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [DW-1:0] live_i,
  input  logic [N-1:0]  flags_i,
  output logic [N-1:0]  mask_o,
  output logic          clr_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o
);
  reg_sel_e       sel;
  logic [N-1:0]   mask_q;
  logic [DW-1:0]  rd_mux;
  logic           unused_hi;

  assign sel       = reg_sel_e'(sel_i);
  assign unused_hi = ^wr_data_i[DW-1:N];
  assign clr_o     = rd_en_i && (sel == SEL_STICKY);

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_LIVE:   rd_mux = live_i;
      SEL_STICKY: rd_mux[N-1:0] = flags_i;
      SEL_MASK:   rd_mux[N-1:0] = mask_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q     <= '0;
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      if (wr_en_i && sel == SEL_MASK) mask_q <= wr_data_i[N-1:0];
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_mux;
    end
  end
  assign mask_o = mask_q;

  // R7
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && sel_i == 2'd2) |=> (mask_q == $past(wr_data_i[N-1:0])));

  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && sel_i == 2'd2) |=> $stable(mask_q));

  // R9
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);
endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
  import irq_stat_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_rdy_i,
  input  logic             ctl_rdy_i,
  input  logic             dec_fail_i,
  input  logic             dec_err_i,
  input  logic             ecc_rdy_i,
  input  logic             wp_fault_i,
  input  logic [CNT_W-1:0] err_cnt_i,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic [1:0]       sel_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_valid_o,
  output logic             irq_o
);
  localparam int LIVE_W = CNT_W + 5;

  logic [SRC_N-1:0] cond, rise, flags, mask;
  logic [DW-1:0]    live;
  logic [CNT_W-1:0] cnt_shown;
  logic             clr;

  // sticky flag order: device, controller, fail, error, ecc, wp (MSB..LSB)
  assign cond = {dev_rdy_i, ctl_rdy_i, dec_fail_i, dec_err_i, ecc_rdy_i, wp_fault_i};

  assign cnt_shown = dec_err_i ? err_cnt_i : '0;
  always_comb begin
    live = '0;
    live[LIVE_W-1:0] = {dec_fail_i, cnt_shown, dec_err_i, ecc_rdy_i, ctl_rdy_i, dev_rdy_i};
  end

  irq_edge_det #(.N(SRC_N)) edge_i (
    .clk(clk), .rst_n(rst_n), .level_i(cond), .rise_o(rise)
  );

  irq_sticky_bank #(.N(SRC_N)) bank_i (
    .clk(clk), .rst_n(rst_n), .set_i(rise), .clr_i(clr), .flags_o(flags)
  );

  irq_reg_port #(.DW(DW), .N(SRC_N)) port_i (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
    .sel_i(sel_i), .wr_data_i(wr_data_i), .live_i(live), .flags_i(flags),
    .mask_o(mask), .clr_o(clr), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );

  assign irq_o = |(flags & mask);

  // R8
  irq_drops_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && sel_i == 2'd1 && rise == '0) |=> !irq_o);

  // R2
  steady_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && $stable(cond)) |=> (flags == '0) || $past(rise) != '0);
endmodule

// File: tb/irq_stat_unit_tb.sv
module irq_stat_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_rdy = 0, ctl_rdy = 0, dec_fail = 0, dec_err = 0, ecc_rdy = 0, wp_fault = 0;
  logic [1:0] err_cnt = 0;
  logic rd_en = 0, wr_en = 0;
  logic [1:0] sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic rd_valid, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_stat_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .dev_rdy_i(dev_rdy), .ctl_rdy_i(ctl_rdy), .dec_fail_i(dec_fail),
    .dec_err_i(dec_err), .ecc_rdy_i(ecc_rdy), .wp_fault_i(wp_fault),
    .err_cnt_i(err_cnt), .rd_en_i(rd_en), .wr_en_i(wr_en), .sel_i(sel),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .rd_valid_o(rd_valid), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic set_src(input logic [5:0] v);
    {dev_rdy, ctl_rdy, dec_fail, dec_err, ecc_rdy, wp_fault} = v;
  endtask

  task automatic reg_read(input logic [1:0] s, output logic [7:0] d);
    rd_en = 1; sel = s;
    @(negedge clk);
    rd_en = 0;
    check("R9 valid", {7'd0, rd_valid}, 8'd1);
    d = rd_data;
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1; sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {7'd0, irq}, 8'd0);
    check("R1 valid", {7'd0, rd_valid}, 8'd0);
    reg_read(2'd2, d); check("R1 mask", d, 8'd0);
    reg_read(2'd1, d); check("R1 sticky", d, 8'd0);

    // R7 mask read/write, upper bits zero
    reg_write(2'd2, 8'hFF);
    reg_read(2'd2, d); check("R7 mask ff", d, 8'h3F);
    reg_write(2'd2, 8'h15);
    reg_read(2'd2, d); check("R7 mask 15", d, 8'h15);

    // R8/R2/R3 sweep: every mask against every source
    for (int m = 0; m < 64; m++) begin
      reg_write(2'd2, 8'(m));
      for (int k = 0; k < 6; k++) begin
        set_src(6'(1 << k));
        @(negedge clk);
        check("R8 irq level", {7'd0, irq}, {7'd0, m[k]});
        set_src(6'd0);
        @(negedge clk);
        check("R8 irq held", {7'd0, irq}, {7'd0, m[k]});
        reg_read(2'd1, d);
        check("R2 R3 sticky bit", d, 8'(1 << k));
        check("R8 irq after clear", {7'd0, irq}, 8'd0);
      end
    end

    // R2 held condition does not set again after clear
    reg_write(2'd2, 8'h3F);
    set_src(6'h20);
    @(negedge clk);
    reg_read(2'd1, d); check("R2 first edge", d, 8'h20);
    repeat (3) @(negedge clk);
    check("R2 no reset irq", {7'd0, irq}, 8'd0);
    reg_read(2'd1, d); check("R2 held no set", d, 8'h00);
    set_src(6'h00);
    @(negedge clk);

    // R4 edge coinciding with a clearing read
    set_src(6'h01);
    @(negedge clk);
    set_src(6'h03);
    reg_read(2'd1, d); check("R4 read old", d, 8'h01);
    check("R4 irq kept", {7'd0, irq}, 8'd1);
    reg_read(2'd1, d); check("R4 survives", d, 8'h02);
    set_src(6'h00);
    @(negedge clk);

    // R6 live read does not clear sticky
    set_src(6'h04);
    @(negedge clk);
    reg_read(2'd0, d);
    check("R6 irq", {7'd0, irq}, 8'd1);
    reg_read(2'd1, d); check("R6 sticky kept", d, 8'h04);
    set_src(6'h00);
    @(negedge clk);

    // R10 writes to other selectors ignored
    set_src(6'h10);
    @(negedge clk);
    set_src(6'h00);
    reg_write(2'd1, 8'h00);
    reg_write(2'd0, 8'hFF);
    reg_write(2'd3, 8'h00);
    reg_read(2'd2, d); check("R10 mask", d, 8'h3F);
    reg_read(2'd1, d); check("R10 sticky", d, 8'h10);
    reg_read(2'd3, d); check("R9 reserved", d, 8'h00);

    // R5 live word sweep over all 128 input combinations
    reg_write(2'd2, 8'h00);
    for (int v = 0; v < 128; v++) begin
      logic [7:0] exp;
      dev_rdy = v[0]; ctl_rdy = v[1]; ecc_rdy = v[2]; dec_err = v[3];
      err_cnt = v[5:4]; dec_fail = v[6];
      exp = 8'(v);
      if (!v[3]) exp[5:4] = 2'b00;
      @(negedge clk);
      reg_read(2'd0, d); check("R5 live", d, exp);
    end
    set_src(6'h00); err_cnt = 0;
    @(negedge clk);
    reg_read(2'd1, d);
    @(negedge clk);
    check("R9 valid low", {7'd0, rd_valid}, 8'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule